// File: doc/BRIEF.md
# Page Permission Extension Checker

This block serves requests that widen the read, write and execute rights of one protected memory page. A request carries the address of a rights descriptor, the 64-bit flags word read from that descriptor, and the address of the target page. The block looks up both pages in a 16-entry page-metadata table. It runs a fixed, ordered series of checks and reports one of two results. On success it ORs the requested rights into the target's entry. On failure it reports a general-protection fault, or a page fault that carries the faulting address. A request is never able to take rights away.

Before the final checks the block takes a busy lock on the target page. Other agents signal the pages they hold through a lock vector, and a target held by another agent is rejected. Once its own lock is taken, the block re-reads the target's metadata. Any change made through the table write port while the lock was being acquired is seen by that second look. The table is loaded through a write port and inspected through a combinational read port.

Top module: `perm_widen_unit`

## Requirements
- R1: `req_ready` is high only while idle. A request is accepted when `req_valid` and `req_ready` are both high at a clock edge. `done` is a one-cycle pulse. It is high in the second cycle after acceptance if the request fails before the lock is taken, and in the third cycle otherwise.
- R2: The first check gives a general-protection fault (`fault_code` 2'b01) if descriptor address bits [5:0] are not zero or target address bits [11:0] are not zero. It takes priority over every other fault.
- R3: Next, a general-protection fault is raised if (address & `range_mask`) differs from `range_base` for either address.
- R4: A page belongs to the table only if address bits [63:16] equal the same bits of parameter `REGION_BASE` (default 64'h10_0000). The table index is address bits [15:12]. If the descriptor is outside the table, a page fault (`fault_code` 2'b10) is raised with `fault_addr` = descriptor address. Otherwise, if the target is outside the table, a page fault is raised with `fault_addr` = target address.
- R5: A page fault on the descriptor address is raised if the descriptor's entry meets any of these: invalid, R clear, pending, modified, blocked, type not 2'b00, owner not `active_owner`, or recorded page field not equal to descriptor address bits [63:12].
- R6: A general-protection fault is raised if any bit of `req_flags` above bit 2 is set. Bit 0 is R, bit 1 is W and bit 2 is X.
- R7: A page fault on the target is raised if the target's entry meets any of these: invalid, pending, modified, blocked, type not 2'b00, or owner not `active_owner`. The recorded page field is not checked at this step.
- R8: A general-protection fault is raised if `other_lock` bit [target index] is set. Otherwise the block sets its own lock bit for the target.
- R9: In the cycle after the lock is taken, the target entry is read again. A page fault on the target is raised if the entry is invalid, pending, modified, of a type other than 2'b00, owned by another ID, or records a page field other than target address bits [63:12]. Table writes that land while the lock is being taken are visible to this check.
- R10: After that, a general-protection fault is raised if the target's R is clear, requested R is clear and requested W is set.
- R11: On success the target's R, W and X bits become the OR of their old values and the requested bits, and no other field changes. A request that adds nothing leaves the entry unchanged.
- R12: `fault_code` is 2'b00 on success. `fault_addr` is zero unless the code is a page fault. `lock_held` has at most one bit set and is zero whenever `done` is high, so the lock drops at the edge that raises `done`.
- R13: An entry is 69 bits, laid out as follows: [0] valid, [1] R, [2] W, [3] X, [4] pending, [5] modified, [6] blocked, [8:7] type, [16:9] owner, [68:17] page field. Reset clears every entry. A table write at the same edge as a rights update to the same entry overrides that update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| range_base | input | 64 | Linear range base |
| range_mask | input | 64 | Linear range mask |
| active_owner | input | 8 | Owner ID of the running context |
| other_lock | input | 16 | Pages held by other agents |
| tbl_we | input | 1 | Table write enable |
| tbl_widx | input | 4 | Table write index |
| tbl_wdata | input | 69 | Table write entry |
| tbl_ridx | input | 4 | Table read index |
| tbl_rdata | output | 69 | Table read entry |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Ready to accept |
| req_desc_addr | input | 64 | Descriptor address |
| req_tgt_addr | input | 64 | Target page address |
| req_flags | input | 64 | Descriptor flags word |
| done | output | 1 | Result pulse |
| fault_code | output | 2 | 00 none, 01 general protection, 10 page fault |
| fault_addr | output | 64 | Faulting address for page faults |
| lock_held | output | 16 | This block's own page lock |

## Verification
The hardest case to reach is a target that passes the first metadata check but fails the second look after the lock is taken. The entry has to change in the single cycle between the two checks. The stimulus reaches this case with a table write timed for the cycle after acceptance, both in a directed test and at random inside the random loop. The bench's model applies that write between its two check stages. Lock conflicts and the W-without-R rule are also mixed into the random requests through biased flags and lock vectors.

// File: rtl/perm_widen_unit.sv
module perm_widen_unit #(
  parameter int IDX_W = 4,
  parameter logic [63:0] REGION_BASE = 64'h0000_0000_0010_0000,
  parameter logic [1:0] PT_REGULAR = 2'b00
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [63:0]       range_base,
  input  logic [63:0]       range_mask,
  input  logic [7:0]        active_owner,
  input  logic [(1<<IDX_W)-1:0] other_lock,
  input  logic              tbl_we,
  input  logic [IDX_W-1:0]  tbl_widx,
  input  logic [68:0]       tbl_wdata,
  input  logic [IDX_W-1:0]  tbl_ridx,
  output logic [68:0]       tbl_rdata,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [63:0]       req_desc_addr,
  input  logic [63:0]       req_tgt_addr,
  input  logic [63:0]       req_flags,
  output logic              done,
  output logic [1:0]        fault_code,
  output logic [63:0]       fault_addr,
  output logic [(1<<IDX_W)-1:0] lock_held
);
  localparam int NENT = 1 << IDX_W;
  localparam int TAG_LO = 12 + IDX_W;
  localparam logic [1:0] FC_NONE = 2'b00, FC_GP = 2'b01, FC_PF = 2'b10;

  typedef enum logic [1:0] {ST_IDLE, ST_FIRST, ST_SECOND} st_t;
  st_t st;

  logic [68:0] tbl [NENT];
  logic [63:0] d_q, t_q, f_q;
  logic [NENT-1:0] lock_q;
  logic        done_q;
  logic [1:0]  code_q;
  logic [63:0] addr_q;

  wire [IDX_W-1:0] d_idx = d_q[TAG_LO-1:12];
  wire [IDX_W-1:0] t_idx = t_q[TAG_LO-1:12];
  wire [68:0] de = tbl[d_idx];
  wire [68:0] te = tbl[t_idx];

  wire misalign = (d_q[5:0] != 6'd0) || (t_q[11:0] != 12'd0);
  wire out_rng  = ((d_q & range_mask) != range_base) || ((t_q & range_mask) != range_base);
  wire d_out    = d_q[63:TAG_LO] != REGION_BASE[63:TAG_LO];
  wire t_out    = t_q[63:TAG_LO] != REGION_BASE[63:TAG_LO];
  wire d_bad    = !de[0] || !de[1] || de[4] || de[5] || de[6] || (de[8:7] != PT_REGULAR) ||
                  (de[16:9] != active_owner) || (de[68:17] != d_q[63:12]);
  wire rsv_bad  = f_q[63:3] != 61'd0;
  wire t_bad    = !te[0] || te[4] || te[5] || te[6] || (te[8:7] != PT_REGULAR) ||
                  (te[16:9] != active_owner);
  wire busy     = other_lock[t_idx];
  wire t_rebad  = !te[0] || te[4] || te[5] || (te[8:7] != PT_REGULAR) ||
                  (te[16:9] != active_owner) || (te[68:17] != t_q[63:12]);
  wire w_no_r   = !te[1] && !f_q[0] && f_q[1];

  logic [1:0]  s1_code, s2_code;
  logic [63:0] s1_addr, s2_addr;

  always_comb begin
    s1_code = FC_NONE;
    s1_addr = '0;
    if (misalign || out_rng)      s1_code = FC_GP;
    else if (d_out)               begin s1_code = FC_PF; s1_addr = d_q; end
    else if (t_out)               begin s1_code = FC_PF; s1_addr = t_q; end
    else if (d_bad)               begin s1_code = FC_PF; s1_addr = d_q; end
    else if (rsv_bad)             s1_code = FC_GP;
    else if (t_bad)               begin s1_code = FC_PF; s1_addr = t_q; end
    else if (busy)                s1_code = FC_GP;
  end

  always_comb begin
    s2_code = FC_NONE;
    s2_addr = '0;
    if (t_rebad)      begin s2_code = FC_PF; s2_addr = t_q; end
    else if (w_no_r)  s2_code = FC_GP;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= ST_IDLE;
      d_q    <= '0;
      t_q    <= '0;
      f_q    <= '0;
      lock_q <= '0;
      done_q <= 1'b0;
      code_q <= FC_NONE;
      addr_q <= '0;
      for (int i = 0; i < NENT; i++) tbl[i] <= '0;
    end else begin
      done_q <= 1'b0;
      case (st)
        ST_IDLE: if (req_valid) begin
          d_q <= req_desc_addr;
          t_q <= req_tgt_addr;
          f_q <= req_flags;
          st  <= ST_FIRST;
        end
        ST_FIRST: begin
          if (s1_code != FC_NONE) begin
            done_q <= 1'b1;
            code_q <= s1_code;
            addr_q <= s1_addr;
            st     <= ST_IDLE;
          end else begin
            lock_q[t_idx] <= 1'b1;
            st <= ST_SECOND;
          end
        end
        default: begin
          done_q <= 1'b1;
          code_q <= s2_code;
          addr_q <= s2_addr;
          lock_q <= '0;
          st     <= ST_IDLE;
          if (s2_code == FC_NONE)
            tbl[t_idx][3:1] <= te[3:1] | f_q[2:0];
        end
      endcase
      if (tbl_we) tbl[tbl_widx] <= tbl_wdata;
    end
  end

  assign req_ready  = (st == ST_IDLE);
  assign done       = done_q;
  assign fault_code = code_q;
  assign fault_addr = addr_q;
  assign lock_held  = lock_q;
  assign tbl_rdata  = tbl[tbl_ridx];
endmodule

module perm_widen_unit_chk #(
  parameter int NENT = 16
) (
  input logic            clk,
  input logic            rst_n,
  input logic            req_valid,
  input logic            req_ready,
  input logic [63:0]     req_desc_addr,
  input logic            done,
  input logic [1:0]      fault_code,
  input logic [63:0]     fault_addr,
  input logic [NENT-1:0] lock_held
);
  a_r1_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> (!req_ready && !done));
  a_r1_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r2_misalign_gp: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_desc_addr[5:0] != 6'd0) |=> ##1 (done && fault_code == 2'b01));
  a_r8_one_lock: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(lock_held));
  a_r12_lock_free_at_done: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (lock_held == '0));
  a_r12_lock_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_held != '0) |=> (done && lock_held == '0));
  a_r12_addr_only_pf: assert property (@(posedge clk) disable iff (!rst_n)
    (done && fault_code != 2'b10) |-> (fault_addr == 64'd0));
  a_r12_code_legal: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (fault_code != 2'b11));
endmodule

bind perm_widen_unit perm_widen_unit_chk #(.NENT(1 << IDX_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_desc_addr(req_desc_addr), .done(done), .fault_code(fault_code),
  .fault_addr(fault_addr), .lock_held(lock_held)
);

// File: tb/perm_widen_unit_tb.sv
module perm_widen_unit_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam logic [63:0] RB = 64'h0000_0000_0010_0000;
  localparam logic [7:0] OWN = 8'h5A;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [63:0] range_base = 64'd0, range_mask = 64'hFFFF_FFFF_FF00_0000;
  logic [7:0] active_owner = OWN;
  logic [15:0] other_lock = '0;
  logic tbl_we = 1'b0;
  logic [3:0] tbl_widx = '0, tbl_ridx = '0;
  logic [68:0] tbl_wdata = '0, tbl_rdata;
  logic req_valid = 1'b0, req_ready, done;
  logic [63:0] req_desc_addr = '0, req_tgt_addr = '0, req_flags = '0, fault_addr;
  logic [1:0] fault_code;
  logic [15:0] lock_held;

  int checks = 0, errors = 0;
  logic [68:0] sh [16];

  always #(CLK_PERIOD/2) clk = ~clk;

  perm_widen_unit dut_i (
    .clk(clk), .rst_n(rst_n), .range_base(range_base), .range_mask(range_mask),
    .active_owner(active_owner), .other_lock(other_lock), .tbl_we(tbl_we),
    .tbl_widx(tbl_widx), .tbl_wdata(tbl_wdata), .tbl_ridx(tbl_ridx), .tbl_rdata(tbl_rdata),
    .req_valid(req_valid), .req_ready(req_ready), .req_desc_addr(req_desc_addr),
    .req_tgt_addr(req_tgt_addr), .req_flags(req_flags), .done(done),
    .fault_code(fault_code), .fault_addr(fault_addr), .lock_held(lock_held)
  );

  task automatic check(input logic ok, input string tag, input logic [68:0] act, input logic [68:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [68:0] mk(input logic [3:0] idx, input logic [2:0] rwx);
    logic [51:0] pa = 52'(RB >> 12) | 52'(idx);
    return {pa, OWN, 2'b00, 3'b000, rwx, 1'b1};
  endfunction

  function automatic logic [63:0] pg(input logic [3:0] idx);
    return RB | (64'(idx) << 12);
  endfunction

  task automatic twrite(input logic [3:0] idx, input logic [68:0] e);
    @(negedge clk);
    tbl_we = 1'b1; tbl_widx = idx; tbl_wdata = e;
    @(negedge clk);
    tbl_we = 1'b0;
    sh[idx] = e;
  endtask

  function automatic logic in_reg(input logic [63:0] a);
    return a[63:16] == RB[63:16];
  endfunction

  // Model of the check order; mutates the shadow table with the mid write and the update.
  task automatic predict(input logic [63:0] d, input logic [63:0] t, input logic [63:0] f,
                         input logic mw, input logic [3:0] mi, input logic [68:0] md,
                         output logic [1:0] c, output logic [63:0] fa, output int lat, output string tag);
    logic [68:0] de, te;
    c = 2'b00; fa = '0; lat = 2; tag = "R11";
    de = sh[d[15:12]]; te = sh[t[15:12]];
    if (d[5:0] != 0 || t[11:0] != 0) begin c = 2'b01; tag = "R2"; end
    else if ((d & range_mask) != range_base || (t & range_mask) != range_base) begin c = 2'b01; tag = "R3"; end
    else if (!in_reg(d)) begin c = 2'b10; fa = d; tag = "R4"; end
    else if (!in_reg(t)) begin c = 2'b10; fa = t; tag = "R4"; end
    else if (!de[0] || !de[1] || de[4] || de[5] || de[6] || de[8:7] != 0 || de[16:9] != OWN || de[68:17] != d[63:12])
      begin c = 2'b10; fa = d; tag = "R5"; end
    else if (f[63:3] != 0) begin c = 2'b01; tag = "R6"; end
    else if (!te[0] || te[4] || te[5] || te[6] || te[8:7] != 0 || te[16:9] != OWN)
      begin c = 2'b10; fa = t; tag = "R7"; end
    else if (other_lock[t[15:12]]) begin c = 2'b01; tag = "R8"; end
    if (mw) sh[mi] = md;
    if (c == 2'b00 && tag == "R11") begin
      lat = 3;
      te = sh[t[15:12]];
      if (!te[0] || te[4] || te[5] || te[8:7] != 0 || te[16:9] != OWN || te[68:17] != t[63:12])
        begin c = 2'b10; fa = t; tag = "R9"; end
      else if (!te[1] && !f[0] && f[1]) begin c = 2'b01; tag = "R10"; end
      else sh[t[15:12]][3:1] = te[3:1] | f[2:0];
    end
  endtask

  task automatic run(input logic [63:0] d, input logic [63:0] t, input logic [63:0] f,
                     input logic mw, input logic [3:0] mi, input logic [68:0] md);
    logic [1:0] ec; logic [63:0] ea; int el; string tg; int n;
    predict(d, t, f, mw, mi, md, ec, ea, el, tg);
    @(negedge clk);
    req_valid = 1'b1; req_desc_addr = d; req_tgt_addr = t; req_flags = f;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    n = 1;
    if (mw) begin tbl_we = 1'b1; tbl_widx = mi; tbl_wdata = md; end
    while (!done && n < 8) begin
      @(negedge clk);
      tbl_we = 1'b0;
      n++;
    end
    tbl_ridx = t[15:12];
    #1;
    check(done && n == el, "R1", 69'(n), 69'(el));
    check(fault_code == ec, tg, 69'(fault_code), 69'(ec));
    check(fault_addr == ea, "R12", 69'(fault_addr), 69'(ea));
    check(lock_held == 16'd0, "R12", 69'(lock_held), 69'd0);
    check(tbl_rdata == sh[t[15:12]], "R11", tbl_rdata, sh[t[15:12]]);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [68:0] e;
    int seed = 32'h1234;
    void'($urandom(seed));
    for (int i = 0; i < 16; i++) sh[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(req_ready && !done && lock_held == 0, "R1", {done, lock_held}, 69'd0);
    tbl_ridx = 4'd3; #1;
    check(tbl_rdata == '0, "R13", tbl_rdata, 69'd0);
    for (int i = 0; i < 16; i++) twrite(4'(i), mk(4'(i), 3'b001));
    tbl_ridx = 4'd5; #1;
    check(tbl_rdata == mk(4'd5, 3'b001), "R13", tbl_rdata, mk(4'd5, 3'b001));

    // R2: misaligned descriptor wins over a bad target entry
    twrite(4'd2, 69'd0);
    run(pg(1) + 64'h8, pg(2), 64'h4, 1'b0, 4'd0, '0);
    twrite(4'd2, mk(4'd2, 3'b001));
    // R3: out of linear range
    run(pg(1), 64'h4000_0000, 64'h4, 1'b0, 4'd0, '0);
    // R4: target outside the table region
    run(pg(1), 64'h0020_0000, 64'h4, 1'b0, 4'd0, '0);
    // R5: descriptor not readable
    twrite(4'd1, mk(4'd1, 3'b000));
    run(pg(1) + 64'h40, pg(2), 64'h4, 1'b0, 4'd0, '0);
    twrite(4'd1, mk(4'd1, 3'b001));
    // R6: reserved flag bit
    run(pg(1), pg(2), 64'h10, 1'b0, 4'd0, '0);
    // R7: target blocked
    e = mk(4'd2, 3'b001); e[6] = 1'b1;
    twrite(4'd2, e);
    run(pg(1), pg(2), 64'h4, 1'b0, 4'd0, '0);
    twrite(4'd2, mk(4'd2, 3'b001));
    // R8: target held elsewhere
    other_lock = 16'h0004;
    run(pg(1), pg(2), 64'h4, 1'b0, 4'd0, '0);
    other_lock = '0;
    // R9: target turns pending while the lock is taken
    e = mk(4'd2, 3'b001); e[4] = 1'b1;
    run(pg(1), pg(2), 64'h4, 1'b1, 4'd2, e);
    twrite(4'd2, mk(4'd2, 3'b001));
    // R10: write without read
    twrite(4'd3, mk(4'd3, 3'b000));
    run(pg(1), pg(3), 64'h2, 1'b0, 4'd0, '0);
    // R11: add X, add nothing, never remove
    run(pg(1), pg(3), 64'h4, 1'b0, 4'd0, '0);
    twrite(4'd4, mk(4'd4, 3'b111));
    run(pg(1), pg(4), 64'h0, 1'b0, 4'd0, '0);
    run(pg(1), pg(4), 64'h1, 1'b0, 4'd0, '0);

    for (int it = 0; it < 300; it++) begin
      logic [3:0] di, ti, mi; logic [63:0] d, t, f; logic mw;
      if (it % 10 == 0) begin
        for (int k = 0; k < 16; k++) begin
          e = mk(4'(k), 3'($urandom));
          if ($urandom % 6 == 0) e[4 + $urandom % 3] = 1'b1;
          if ($urandom % 10 == 0) e[0] = 1'b0;
          if ($urandom % 12 == 0) e[16:9] = 8'h11;
          if ($urandom % 12 == 0) e[8:7] = 2'b01;
          if ($urandom % 12 == 0) e[17] = ~e[17];
          twrite(4'(k), e);
        end
      end
      di = 4'($urandom); ti = 4'($urandom);
      d = pg(di) | (64'($urandom % 64) << 6);
      if ($urandom % 20 == 0) d = d + 64'h4;
      t = pg(ti);
      if ($urandom % 20 == 0) t = t + 64'h100;
      if ($urandom % 25 == 0) t = 64'h0030_0000;
      f = 64'($urandom % 8);
      if ($urandom % 20 == 0) f[40] = 1'b1;
      other_lock = ($urandom % 8 == 0) ? 16'(1 << ($urandom % 16)) : 16'd0;
      mw = ($urandom % 5 == 0);
      mi = ($urandom % 2 == 0) ? ti : 4'($urandom);
      e = mk(mi, 3'($urandom));
      if ($urandom % 2 == 0) e[4 + $urandom % 2] = 1'b1;
      run(d, t, f, mw, mi, e);
    end
    other_lock = '0;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule